// File: doc/BRIEF.md
# Set-Selected Event Counter Bank

This block is a register-mapped bank of 64-bit event counters for a core's private cache. Each counter is paired with a selector register. The selector names one of four event groups and holds a mask of the events within that group. Every clock cycle, each counter checks whether any masked event of its chosen group is active. If so, the counter advances by one, regardless of how many of the masked events are active in that cycle.

Software reaches the selectors and counters through a plain 32-bit register port. The write strobe, address and data are sampled on the rising clock edge, and read data is returned combinationally from the current address. A 64-bit register is accessed as two 32-bit words. The typical sequence is:
1. Clear the counter.
2. Write the selector to start counting.
3. Write zero to the selector to stop counting.
4. Read both halves of the counter.

Top module: `pmc_bank`

## Requirements
- R1: After a synchronous reset, every selector and every counter reads zero.
- R2: Selector i sits at byte address 0x2000 + 8*i and counter i at 0x3000 + 8*i, for i from 0 to 63. Within each register, address bit 2 picks the word: 0 is bits [31:0] and 1 is bits [63:32]. Address bits [1:0] must be zero.
- R3: A selector stores only bits [27:0] of its low word. Selector bits [63:28] always read zero, and writes to them have no effect.
- R4: A counter whose selection matches in a cycle holds its old value plus one after that clock edge. It rises by exactly one even when several selected events fire together.
- R5: Selector bits [7:0] choose the group. The values 1, 2, 3 and 4 select groups of 20, 19, 14 and 1 events, driven on `ev_grp1`..`ev_grp4`. Selector bit 8+k enables event k of the chosen group. Any other group value never counts.
- R6: A mask bit at or above the chosen group's event count never causes a count.
- R7: A selector holding zero stops its counter, and the count then holds. The selector is sampled before its own write, so the edge that writes zero still counts.
- R8: Each 32-bit half of a counter is writable on its own, and a write to one half leaves the other half unchanged.
- R9: A counter write in the same cycle as a matching event wins. The counter holds the written word and is not incremented on that edge.
- R10: A count carries from bit 31 into bit 32, and all-ones wraps to zero.
- R11: A read of any unmapped address, including one with a non-zero bits [1:0], returns zero. A write to an unmapped address changes no register.
- R12: Counters count independently of one another, each by its own selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 14 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_grp1 | input | 20 | Per-cycle event flags of group 1 |
| ev_grp2 | input | 19 | Per-cycle event flags of group 2 |
| ev_grp3 | input | 14 | Per-cycle event flags of group 3 |
| ev_grp4 | input | 1 | Per-cycle event flag of group 4 |

## Verification
The counting function is tried with the following patterns, each of which separates a different fault:
- A single masked event in each of the four groups, including the top event of groups 2 and 3, which catches wrong bit offsets.
- Two or all masked events firing together, which catches counting per event instead of per cycle.
- Events that are active but unmasked, and events active only in another group, which catch wrong group routing.
- Group values of 0 and 5 with every event active.
- Mask bits beyond a group's size with every event of that group active.

Directed cases cover the carry from the low word into the high word and the full wrap to zero. They also cover a counter write on an event edge, a selector cleared while events keep firing, two counters running concurrently from different groups, and writes to misaligned or out-of-range addresses.

// File: rtl/pmc_pkg.sv
// Package: shared constants and types for the event counter bank.
// Assumes a 32-bit register port and 64-bit counters.
package pmc_pkg;
    localparam int WORD_W   = 32;
    localparam int CNT_W    = 64;
    localparam int SET_W    = 8;
    localparam int EV_MAX   = 20;
    localparam int SEL_W    = SET_W + EV_MAX;
    localparam int NUM_SETS = 4;
    localparam int EV_N1    = 20;
    localparam int EV_N2    = 19;
    localparam int EV_N3    = 14;
    localparam int EV_N4    = 1;

    // Which register array an address falls into
    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_SEL  = 2'd1,
        RK_CNT  = 2'd2
    } reg_kind_e;

    // All groups zero-extended to the widest group
    typedef logic [NUM_SETS-1:0][EV_MAX-1:0] ev_pad_t;
endpackage

// File: rtl/pmc_addr_dec.sv
// Address decoder: maps a byte address onto the selector array, the
// counter array or nothing. Assumes both regions use an 8-byte stride
// and that address bits [1:0] must be zero.
module pmc_addr_dec
    import pmc_pkg::*;
#(
    parameter int              NUM_CTR  = 64,
    parameter int              ADDR_W   = 14,
    parameter logic [ADDR_W-1:0] SEL_BASE = 14'h2000,
    parameter logic [ADDR_W-1:0] CNT_BASE = 14'h3000,
    parameter int              IDX_W    = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  idx,
    output logic              upper
);
    localparam int SPAN = NUM_CTR * 8;
    localparam logic [ADDR_W:0] SPAN_V = (ADDR_W+1)'(SPAN);

    logic [ADDR_W:0] sel_off;
    logic [ADDR_W:0] cnt_off;
    logic            aligned;
    logic            in_sel;
    logic            in_cnt;

    // Offsets from each region base, with a borrow bit to catch underflow
    always_comb begin
        sel_off = {1'b0, addr} - {1'b0, SEL_BASE};
        cnt_off = {1'b0, addr} - {1'b0, CNT_BASE};
        aligned = (addr[1:0] == 2'b00);
        in_sel  = aligned && !sel_off[ADDR_W] && (sel_off < SPAN_V);
        in_cnt  = aligned && !cnt_off[ADDR_W] && (cnt_off < SPAN_V);
    end

    // Region choice and register index
    always_comb begin
        kind  = RK_NONE;
        idx   = '0;
        upper = addr[2];
        if (in_sel) begin
            kind = RK_SEL;
            idx  = sel_off[IDX_W+2:3];
        end else if (in_cnt) begin
            kind = RK_CNT;
            idx  = cnt_off[IDX_W+2:3];
        end
    end
endmodule

// File: rtl/pmc_event_match.sv
// Event matcher: raises hit when any mask bit of the selector meets an
// active event of the group named in the selector's low byte.
// Assumes each group is zero-padded above its own event count.
module pmc_event_match
    import pmc_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  ev_pad_t          ev_pad,
    output logic             hit
);
    logic [EV_MAX-1:0] mask;

    // OR of masked events over the one group whose number matches
    always_comb begin
        mask = sel[SEL_W-1:SET_W];
        hit  = 1'b0;
        for (int s = 0; s < NUM_SETS; s++) begin
            if (sel[SET_W-1:0] == SET_W'(s + 1)) begin
                hit = hit | (|(mask & ev_pad[s]));
            end
        end
    end
endmodule

// File: rtl/pmc_counter_slot.sv
// One counter slot: a selector register and a 64-bit counter.
// A word write to the counter takes precedence over the increment.
// Assumes at most one write strobe is active per cycle.
module pmc_counter_slot
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic              cnt_wr_lo,
    input  logic              cnt_wr_hi,
    input  logic              bump,
    input  logic [WORD_W-1:0] wdata,
    output logic [SEL_W-1:0]  sel_q,
    output logic [CNT_W-1:0]  cnt_q
);
    // Selector register, only its implemented bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_wr) begin
            sel_q <= wdata[SEL_W-1:0];
        end
    end

    // Counter: a word write first, otherwise a one-step advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr_lo) begin
            cnt_q[WORD_W-1:0] <= wdata;
        end else if (cnt_wr_hi) begin
            cnt_q[CNT_W-1:WORD_W] <= wdata;
        end else if (bump) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pmc_bank.sv
// Top of the event counter bank. Decodes the register port, fans write
// strobes out to NUM_CTR slots, matches events per slot and muxes reads.
// Assumes reads are combinational from reg_addr and writes take one edge.
module pmc_bank
    import pmc_pkg::*;
#(
    parameter int                NUM_CTR  = 64,
    parameter int                ADDR_W   = 14,
    parameter logic [ADDR_W-1:0] SEL_BASE = 14'h2000,
    parameter logic [ADDR_W-1:0] CNT_BASE = 14'h3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [EV_N1-1:0]  ev_grp1,
    input  logic [EV_N2-1:0]  ev_grp2,
    input  logic [EV_N3-1:0]  ev_grp3,
    input  logic [EV_N4-1:0]  ev_grp4
);
    localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

    reg_kind_e          acc_kind;
    logic [IDX_W-1:0]   acc_idx;
    logic               acc_upper;
    ev_pad_t            ev_pad;
    logic [NUM_CTR-1:0] hit_vec;
    logic [NUM_CTR-1:0] sel_wr;
    logic [NUM_CTR-1:0] cnt_wr_lo;
    logic [NUM_CTR-1:0] cnt_wr_hi;
    logic [SEL_W-1:0]   sel_q [NUM_CTR];
    logic [CNT_W-1:0]   cnt_q [NUM_CTR];

    pmc_addr_dec #(
        .NUM_CTR  (NUM_CTR),
        .ADDR_W   (ADDR_W),
        .SEL_BASE (SEL_BASE),
        .CNT_BASE (CNT_BASE),
        .IDX_W    (IDX_W)
    ) u_dec (
        .addr  (reg_addr),
        .kind  (acc_kind),
        .idx   (acc_idx),
        .upper (acc_upper)
    );

    // Zero-extend every group to the common width
    always_comb begin
        ev_pad[0] = EV_MAX'(ev_grp1);
        ev_pad[1] = EV_MAX'(ev_grp2);
        ev_pad[2] = EV_MAX'(ev_grp3);
        ev_pad[3] = EV_MAX'(ev_grp4);
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
        // Write strobes for this slot; selector upper word has no storage
        always_comb begin
            sel_wr[i]    = reg_wr && (acc_kind == RK_SEL) && (acc_idx == IDX_W'(i)) && !acc_upper;
            cnt_wr_lo[i] = reg_wr && (acc_kind == RK_CNT) && (acc_idx == IDX_W'(i)) && !acc_upper;
            cnt_wr_hi[i] = reg_wr && (acc_kind == RK_CNT) && (acc_idx == IDX_W'(i)) && acc_upper;
        end

        pmc_event_match u_match (
            .sel    (sel_q[i]),
            .ev_pad (ev_pad),
            .hit    (hit_vec[i])
        );

        pmc_counter_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel_wr    (sel_wr[i]),
            .cnt_wr_lo (cnt_wr_lo[i]),
            .cnt_wr_hi (cnt_wr_hi[i]),
            .bump      (hit_vec[i]),
            .wdata     (reg_wdata),
            .sel_q     (sel_q[i]),
            .cnt_q     (cnt_q[i])
        );
    end

    // Read mux: selector words, counter words, or zero
    always_comb begin
        reg_rdata = '0;
        case (acc_kind)
            RK_SEL: begin
                if (!acc_upper) begin
                    reg_rdata = WORD_W'(sel_q[acc_idx]);
                end
            end
            RK_CNT: begin
                reg_rdata = acc_upper ? cnt_q[acc_idx][CNT_W-1:WORD_W]
                                      : cnt_q[acc_idx][WORD_W-1:0];
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pmc_bank_chk.sv
// Checker for pmc_bank: per-slot counting, write precedence and hold
// properties, plus zero read data on unmapped addresses. Bound below.
module pmc_bank_chk
    import pmc_pkg::*;
#(
    parameter int                NUM_CTR  = 64,
    parameter int                ADDR_W   = 14,
    parameter logic [ADDR_W-1:0] SEL_BASE = 14'h2000,
    parameter logic [ADDR_W-1:0] CNT_BASE = 14'h3000
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [WORD_W-1:0]  reg_wdata,
    input logic [WORD_W-1:0]  reg_rdata,
    input logic [NUM_CTR-1:0] hit_vec,
    input logic [NUM_CTR-1:0] cnt_wr_lo,
    input logic [NUM_CTR-1:0] cnt_wr_hi,
    input logic [SEL_W-1:0]   sel_q [NUM_CTR],
    input logic [CNT_W-1:0]   cnt_q [NUM_CTR]
);
    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        int av;
        av = int'(a);
        return (a[1:0] == 2'b00) &&
               (((av >= int'(SEL_BASE)) && (av < int'(SEL_BASE) + NUM_CTR * 8)) ||
                ((av >= int'(CNT_BASE)) && (av < int'(CNT_BASE) + NUM_CTR * 8)));
    endfunction

    // R11: unmapped reads return zero
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !is_mapped(reg_addr) |-> (reg_rdata == '0));

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
        // R4: a matching cycle without a write adds exactly one
        p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_vec[i] && !cnt_wr_lo[i] && !cnt_wr_hi[i])
            |=> (cnt_q[i] == $past(cnt_q[i]) + CNT_W'(1)));

        // R7: no match and no write keeps the count
        p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit_vec[i] && !cnt_wr_lo[i] && !cnt_wr_hi[i]) |=> $stable(cnt_q[i]));

        // R7: an all-zero selector never matches
        p_zero_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_q[i] == '0) |-> !hit_vec[i]);

        // R9: a low-word write lands exactly, with no increment
        p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_wr_lo[i] |=> (cnt_q[i][WORD_W-1:0] == $past(reg_wdata)));

        // R8: a low-word write leaves the upper word untouched
        p_other_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_wr_lo[i] |=> (cnt_q[i][CNT_W-1:WORD_W] == $past(cnt_q[i][CNT_W-1:WORD_W])));
    end
endmodule

bind pmc_bank pmc_bank_chk #(
    .NUM_CTR  (NUM_CTR),
    .ADDR_W   (ADDR_W),
    .SEL_BASE (SEL_BASE),
    .CNT_BASE (CNT_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .hit_vec   (hit_vec),
    .cnt_wr_lo (cnt_wr_lo),
    .cnt_wr_hi (cnt_wr_hi),
    .sel_q     (sel_q),
    .cnt_q     (cnt_q)
);

// File: tb/pmc_bank_test.sv
`timescale 1ns/1ps
module pmc_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [13:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [19:0] ev1 = '0;
    logic [18:0] ev2 = '0;
    logic [13:0] ev3 = '0;
    logic [0:0]  ev4 = '0;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    pmc_bank uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_grp1(ev1), .ev_grp2(ev2), .ev_grp3(ev3), .ev_grp4(ev4)
    );

    typedef struct packed {
        logic [31:0] idx, sel, e1, e2, e3, e4, n, exp;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{32'd0,  32'h0000_0101, 32'h1,     32'h0,     32'h0,    32'h0, 32'd3, 32'd3},
        '{32'd5,  32'h0000_2101, 32'h21,    32'h0,     32'h0,    32'h0, 32'd4, 32'd4},
        '{32'd9,  32'h0000_0101, 32'h2,     32'h0,     32'h0,    32'h0, 32'd3, 32'd0},
        '{32'd63, 32'h0400_0002, 32'h0,     32'h40000, 32'h0,    32'h0, 32'd2, 32'd2},
        '{32'd17, 32'h0020_0003, 32'h0,     32'h0,     32'h2000, 32'h0, 32'd5, 32'd5},
        '{32'd33, 32'h0000_0104, 32'h0,     32'h0,     32'h0,    32'h1, 32'd3, 32'd3},
        '{32'd40, 32'h0FFF_FF00, 32'hFFFFF, 32'h7FFFF, 32'h3FFF, 32'h1, 32'd4, 32'd0},
        '{32'd41, 32'h0FFF_FF05, 32'hFFFFF, 32'h7FFFF, 32'h3FFF, 32'h1, 32'd4, 32'd0},
        '{32'd42, 32'h0000_0101, 32'h0,     32'h1,     32'h1,    32'h1, 32'd3, 32'd0},
        '{32'd43, 32'h0000_0204, 32'h0,     32'h0,     32'h0,    32'h1, 32'd3, 32'd0},
        '{32'd44, 32'h0800_0002, 32'h0,     32'h7FFFF, 32'h0,    32'h0, 32'd3, 32'd0},
        '{32'd45, 32'h07FF_FF02, 32'h0,     32'h7FFFF, 32'h0,    32'h0, 32'd6, 32'd6}
    };

    function automatic logic [13:0] sel_a(input int i, input bit hi);
        return 14'(14'h2000 + i * 8 + (hi ? 4 : 0));
    endfunction

    function automatic logic [13:0] cnt_a(input int i, input bit hi);
        return 14'(14'h3000 + i * 8 + (hi ? 4 : 0));
    endfunction

    // Called at a falling edge; the write takes the next rising edge
    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d);
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(cnt_a(0, 0), rv);  chk("R1 counter 0 low", rv, 32'h0);
        rd(cnt_a(63, 1), rv); chk("R1 counter 63 high", rv, 32'h0);
        rd(sel_a(63, 0), rv); chk("R1 selector 63", rv, 32'h0);

        // Table: R4/R5/R6/R12 counting patterns
        for (int k = 0; k < NVEC; k++) begin
            vec_t v;
            v = VECS[k];
            wr(cnt_a(int'(v.idx), 0), 32'h0);
            wr(cnt_a(int'(v.idx), 1), 32'h0);
            wr(sel_a(int'(v.idx), 0), v.sel);
            ev1 = v.e1[19:0]; ev2 = v.e2[18:0]; ev3 = v.e3[13:0]; ev4 = v.e4[0:0];
            repeat (int'(v.n)) @(negedge clk);
            ev1 = '0; ev2 = '0; ev3 = '0; ev4 = '0;
            wr(sel_a(int'(v.idx), 0), 32'h0);
            rd(cnt_a(int'(v.idx), 0), rv);
            chk($sformatf("R4/R5/R6 vector %0d low", k), rv, v.exp);
            rd(cnt_a(int'(v.idx), 1), rv);
            chk($sformatf("R4/R5 vector %0d high", k), rv, 32'h0);
        end

        // R2/R8: split halves of a counter
        wr(cnt_a(7, 0), 32'hDEAD_BEEF);
        rd(cnt_a(7, 0), rv); chk("R2 counter 7 low", rv, 32'hDEAD_BEEF);
        wr(cnt_a(7, 1), 32'h1234_5678);
        rd(cnt_a(7, 1), rv); chk("R2 counter 7 high", rv, 32'h1234_5678);
        rd(cnt_a(7, 0), rv); chk("R8 low kept after high write", rv, 32'hDEAD_BEEF);

        // R3: selector implemented bits
        wr(sel_a(10, 0), 32'hFFFF_FFFF);
        rd(sel_a(10, 0), rv); chk("R3 selector low bits", rv, 32'h0FFF_FFFF);
        wr(sel_a(10, 1), 32'hFFFF_FFFF);
        rd(sel_a(10, 1), rv); chk("R3 selector high word", rv, 32'h0);
        wr(sel_a(10, 0), 32'h0);

        // R10: carry into the upper word and full wrap
        wr(cnt_a(3, 0), 32'hFFFF_FFFF);
        wr(sel_a(3, 0), 32'h0000_0101);
        ev1 = 20'h1; @(negedge clk); ev1 = '0;
        rd(cnt_a(3, 0), rv); chk("R10 carry low", rv, 32'h0);
        rd(cnt_a(3, 1), rv); chk("R10 carry high", rv, 32'h1);
        wr(cnt_a(3, 1), 32'hFFFF_FFFF);
        wr(cnt_a(3, 0), 32'hFFFF_FFFF);
        ev1 = 20'h1; @(negedge clk); ev1 = '0;
        wr(sel_a(3, 0), 32'h0);
        rd(cnt_a(3, 0), rv); chk("R10 wrap low", rv, 32'h0);
        rd(cnt_a(3, 1), rv); chk("R10 wrap high", rv, 32'h0);

        // R9: write on the same edge as an event
        wr(sel_a(2, 0), 32'h0000_0101);
        ev1 = 20'h1;
        wr(cnt_a(2, 0), 32'h0000_0100);
        ev1 = '0;
        rd(cnt_a(2, 0), rv); chk("R9 write beats increment", rv, 32'h0000_0100);
        ev1 = 20'h1; @(negedge clk); ev1 = '0;
        rd(cnt_a(2, 0), rv); chk("R4 next edge counts", rv, 32'h0000_0101);
        wr(sel_a(2, 0), 32'h0);

        // R7: clearing the selector while events keep firing
        wr(sel_a(12, 0), 32'h0000_0101);
        ev1 = 20'h1;
        repeat (2) @(negedge clk);
        wr(sel_a(12, 0), 32'h0);
        repeat (4) @(negedge clk);
        ev1 = '0;
        rd(cnt_a(12, 0), rv); chk("R7 count held after disable", rv, 32'd3);

        // R12: two counters from different groups at once
        wr(sel_a(20, 0), 32'h0000_0101);
        wr(sel_a(21, 0), 32'h0000_0103);
        ev1 = 20'h1; ev3 = 14'h1;
        repeat (3) @(negedge clk);
        ev1 = '0;
        repeat (2) @(negedge clk);
        ev3 = '0;
        wr(sel_a(20, 0), 32'h0);
        wr(sel_a(21, 0), 32'h0);
        rd(cnt_a(20, 0), rv); chk("R12 counter 20", rv, 32'd3);
        rd(cnt_a(21, 0), rv); chk("R12 counter 21", rv, 32'd5);

        // R11: unmapped and misaligned accesses
        wr(14'h1000, 32'hFFFF_FFFF);
        wr(14'h2200, 32'hFFFF_FFFF);
        wr(14'h3200, 32'hFFFF_FFFF);
        wr(14'h3002, 32'hFFFF_FFFF);
        wr(14'h2002, 32'h0000_0101);
        rd(14'h1000, rv); chk("R11 read 0x1000", rv, 32'h0);
        rd(14'h2200, rv); chk("R11 read past selectors", rv, 32'h0);
        rd(14'h3002, rv); chk("R11 read misaligned", rv, 32'h0);
        rd(cnt_a(0, 0), rv); chk("R11 counter 0 untouched", rv, 32'd3);
        rd(sel_a(0, 0), rv); chk("R11 selector 0 untouched", rv, 32'h0);

        finish_run();
    end
endmodule